// File: doc/BRIEF.md
# Memory-Driven DAC Waveform Scanner

This block produces the digital input word for a DAC. The word comes from one of two sources: a static data register that the host loads directly, or a 64-word waveform memory. A scan pointer addresses the memory and moves one location per rate tick. The tick period is the system clock divided by 512 >> n, where n is a 3-bit rate code. With an 18.432 MHz clock this gives 36 kHz × 2^n.

A small state machine sequences the pointer. ST_PARK is the idle state at a sweep end. ST_RISE and ST_FALL are single sweeps. ST_TRI_UP and ST_TRI_DN are the two halves of the continuous triangle scan. The transitions are:

- PARK→RISE or PARK→FALL on a tick when the direction bit points away from the current end.
- RISE→PARK on reaching the top location, and FALL→PARK on reaching the bottom location.
- PARK→TRI_UP or PARK→TRI_DN on a tick with auto-cycle set.
- TRI_UP→TRI_DN at the top location, and TRI_DN→TRI_UP at the bottom location.
- TRI_UP→RISE and TRI_DN→FALL when auto-cycle is cleared.

Direction and auto-cycle are read only in ST_PARK. A sweep in progress therefore finishes before a new setting applies. Every state freezes while the source bit selects the static register.

Top module: `wave_dac_scan`

## Requirements
- R1: After reset the control readback is 0x00, the DAC output equals the static register (reset value 0), and the pointer sits at location 0.
- R2: Control byte layout: bits 5:3 rate code n, bit 2 direction (1 = up), bit 1 auto-cycle, bit 0 source select (1 = memory). Bits 7:6 always read back as 0, whatever was written.
- R3: With source select 0, the DAC output equals the static register one clock after the register is written. Static writes made while the memory is selected do not change the output.
- R4: With source select 1, the output is the memory word at the pointer. It appears the clock after a control write sets the bit, and one clock after each pointer step.
- R5: Pointer steps occur every 512 >> n clocks. A control write restarts the divider and cancels any tick due on its own cycle. Step k after a write at edge P is visible after edge P + k·(512 >> n) + 1.
- R6: With direction 1 and auto-cycle 0, the pointer climbs to location 63 and stays there.
- R7: With direction 0 and auto-cycle 0, the pointer falls to location 0 and stays there.
- R8: A direction change written during a sweep takes effect only after the sweep reaches its end. The next tick then starts the opposite sweep.
- R9: With auto-cycle 1, the pointer runs 0→63→0 repeatedly. Each end location is shown for exactly one tick.
- R10: Auto-cycle has no effect while source select is 0: the output stays on the static register.
- R11: Clearing source select freezes the pointer. Setting it again resumes from the frozen location in the same sweep.
- R12: A host memory write is read-first. A write to the location under the pointer reaches the output one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte readback |
| dat_we | input | 1 | Static data register write strobe |
| dat_wdata | input | 10 | Static data value |
| mem_we | input | 1 | Waveform memory write strobe |
| mem_waddr | input | 6 | Waveform memory write address |
| mem_wdata | input | 10 | Waveform memory write word |
| dac_out | output | 10 | DAC input word |

## Verification
Two things can land on the same clock edge: a control write and a pointer step that the rate divider has made due. The bench provokes this during a falling sweep. It times a direction write so that its edge is exactly the edge on which the eleventh step would occur. The scoreboard then expects two things. First, no step on that edge. Second, a fresh full divider period before the next step, with that step and the rest of the sweep still moving downward, before the new direction applies at the bottom.

// File: rtl/wave_dac_pkg.sv
`timescale 1ns/1ps
package wave_dac_pkg;

    localparam int RATE_W = 3;

    typedef enum logic [2:0] {
        ST_PARK   = 3'd0,
        ST_RISE   = 3'd1,
        ST_FALL   = 3'd2,
        ST_TRI_UP = 3'd3,
        ST_TRI_DN = 3'd4
    } scan_state_e;

    typedef struct packed {
        logic [1:0]        rsvd;
        logic [RATE_W-1:0] rate;
        logic              dir_up;
        logic              auto_cyc;
        logic              mem_src;
    } ctrl_t;

endpackage

// File: rtl/rate_tick_gen.sv
`timescale 1ns/1ps
module rate_tick_gen #(
    parameter int RATE_W   = 3,
    parameter int BASE_DIV = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = $clog2(BASE_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   period;
    logic             at_end;

    // period = BASE_DIV >> rate, never below one clock
    assign period = (CNT_W + 1)'(BASE_DIV) >> rate;
    assign at_end = (cnt_q == CNT_W'(period - 1'b1));
    assign tick   = at_end && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq
    import wave_dac_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              dir_up,
    input  logic              auto_cyc,
    output logic [ADDR_W-1:0] ptr,
    output scan_state_e       state
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] BOT = '0;

    scan_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [ADDR_W-1:0] ptr_up, ptr_dn;

    assign ptr_up = ptr_q + 1'b1;
    assign ptr_dn = ptr_q - 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            ptr_q   <= BOT;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (run && tick) begin
            unique case (state_q)
                ST_PARK: begin
                    if (auto_cyc) begin
                        if (ptr_q == TOP) begin
                            ptr_d   = ptr_dn;
                            state_d = ST_TRI_DN;
                        end else begin
                            ptr_d   = ptr_up;
                            state_d = ST_TRI_UP;
                        end
                    end else if (dir_up && ptr_q != TOP) begin
                        ptr_d   = ptr_up;
                        state_d = (ptr_up == TOP) ? ST_PARK : ST_RISE;
                    end else if (!dir_up && ptr_q != BOT) begin
                        ptr_d   = ptr_dn;
                        state_d = (ptr_dn == BOT) ? ST_PARK : ST_FALL;
                    end
                end
                ST_RISE: begin
                    ptr_d   = ptr_up;
                    state_d = (ptr_up == TOP) ? ST_PARK : ST_RISE;
                end
                ST_FALL: begin
                    ptr_d   = ptr_dn;
                    state_d = (ptr_dn == BOT) ? ST_PARK : ST_FALL;
                end
                ST_TRI_UP: begin
                    if (!auto_cyc) begin
                        if (ptr_q == TOP) begin
                            state_d = ST_PARK;
                        end else begin
                            ptr_d   = ptr_up;
                            state_d = (ptr_up == TOP) ? ST_PARK : ST_RISE;
                        end
                    end else if (ptr_q == TOP) begin
                        ptr_d   = ptr_dn;
                        state_d = ST_TRI_DN;
                    end else begin
                        ptr_d   = ptr_up;
                    end
                end
                ST_TRI_DN: begin
                    if (!auto_cyc) begin
                        if (ptr_q == BOT) begin
                            state_d = ST_PARK;
                        end else begin
                            ptr_d   = ptr_dn;
                            state_d = (ptr_dn == BOT) ? ST_PARK : ST_FALL;
                        end
                    end else if (ptr_q == BOT) begin
                        ptr_d   = ptr_up;
                        state_d = ST_TRI_UP;
                    end else begin
                        ptr_d   = ptr_dn;
                    end
                end
                default: begin
                    state_d = ST_PARK;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ptr   = ptr_q;
        state = state_q;
    end
endmodule

// File: rtl/wave_mem.sv
`timescale 1ns/1ps
module wave_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // read-first: a same-edge write is seen on the following read
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/wave_dac_scan.sv
`timescale 1ns/1ps
module wave_dac_scan
    import wave_dac_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 10,
    parameter int BASE_DIV = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dac_out
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] static_q;
    logic              rate_tick;
    logic [ADDR_W-1:0] scan_ptr;
    scan_state_e       seq_state;
    logic [DATA_W-1:0] mem_rdata;
    logic              ctrl_rsvd_unused;

    assign ctrl_rsvd_unused = ^ctrl_wdata[7:6];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            static_q <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.rsvd     <= 2'b00;
                ctrl_q.rate     <= ctrl_wdata[5:3];
                ctrl_q.dir_up   <= ctrl_wdata[2];
                ctrl_q.auto_cyc <= ctrl_wdata[1];
                ctrl_q.mem_src  <= ctrl_wdata[0];
            end
            if (dat_we) begin
                static_q <= dat_wdata;
            end
        end
    end

    rate_tick_gen #(
        .RATE_W   (RATE_W),
        .BASE_DIV (BASE_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_we),
        .rate    (ctrl_q.rate),
        .tick    (rate_tick)
    );

    scan_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (rate_tick),
        .run      (ctrl_q.mem_src),
        .dir_up   (ctrl_q.dir_up),
        .auto_cyc (ctrl_q.auto_cyc),
        .ptr      (scan_ptr),
        .state    (seq_state)
    );

    wave_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (scan_ptr),
        .rdata (mem_rdata)
    );

    assign ctrl_rdata = ctrl_q;
    assign dac_out    = ctrl_q.mem_src ? mem_rdata : static_q;
endmodule

// File: rtl/wave_dac_scan_chk.sv
`timescale 1ns/1ps
module wave_dac_scan_chk
    import wave_dac_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              auto_cyc,
    input logic              ctrl_we,
    input logic              dat_we,
    input logic [DATA_W-1:0] dat_wdata,
    input logic [DATA_W-1:0] dac_out,
    input logic [ADDR_W-1:0] ptr,
    input scan_state_e       state
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ptr) |-> $past(tick && run)) else $error("pointer moved without tick"); // R5

    AST_FROZEN_PTR: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(ptr)) else $error("pointer moved while frozen"); // R11

    AST_STATIC_PATH: assert property (@(posedge clk) disable iff (!rst_n) (dat_we && !run && !ctrl_we) |=> (dac_out == $past(dat_wdata))) else $error("static word not output"); // R3

    AST_RISE_HOLDS_DIR: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RISE && tick && run) |=> (ptr == $past(ptr) + 1'b1)) else $error("rising sweep reversed"); // R8

    AST_FALL_HOLDS_DIR: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FALL && tick && run) |=> (ptr == $past(ptr) - 1'b1)) else $error("falling sweep reversed"); // R8

    AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_TRI_UP && auto_cyc && tick && run && ptr == TOP) |=> (ptr == TOP - 1'b1)) else $error("bad turn at top"); // R9

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n) (ptr == TOP) |=> (ptr != '0)) else $error("wrapped over top"); // R6

    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n) (ptr == '0) |=> (ptr != TOP)) else $error("wrapped under bottom"); // R7
endmodule

bind wave_dac_scan wave_dac_scan_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (rate_tick),
    .run       (ctrl_q.mem_src),
    .auto_cyc  (ctrl_q.auto_cyc),
    .ctrl_we   (ctrl_we),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .dac_out   (dac_out),
    .ptr       (scan_ptr),
    .state     (seq_state)
);

// File: tb/wave_dac_scan_test.sv
`timescale 1ns/1ps
module wave_dac_scan_test;
    localparam int AW = 6;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_we = 1'b0;
    logic [7:0]    ctrl_wdata = '0;
    logic [7:0]    ctrl_rdata;
    logic          dat_we = 1'b0;
    logic [DW-1:0] dat_wdata = '0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [DW-1:0] dac_out;

    always #4 clk = ~clk;

    wave_dac_scan uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .dat_we     (dat_we),
        .dat_wdata  (dat_wdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .dac_out    (dac_out)
    );

    typedef struct {
        int            cyc;
        logic [DW-1:0] val;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    exp_t          mon_e;
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;
    string         phase = "R1";
    logic [DW-1:0] prev_dac;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mv(int a);
        return DW'((a * 13 + 5) % 1024);
    endfunction

    task automatic push(int c, logic [DW-1:0] v, string r);
        exp_t e;
        e.cyc = c;
        e.val = v;
        e.req = r;
        sbq.push_back(e);
    endtask

    task automatic check_eq(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    // scoreboard monitor: every change of dac_out must match the queue head
    always @(negedge clk) begin
        if (mon_on) begin
            while (sbq.size() != 0 && sbq[0].cyc < cyc) begin
                mon_e = sbq.pop_front();
                n_chk++;
                n_fail++;
                $display("FAIL %s: actual %h (no change) expected %h at cycle %0d",
                         mon_e.req, dac_out, mon_e.val, mon_e.cyc);
            end
            if (dac_out !== prev_dac) begin
                n_chk++;
                if (sbq.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s: actual %h at cycle %0d expected unchanged %h",
                             phase, dac_out, cyc, prev_dac);
                end else begin
                    mon_e = sbq.pop_front();
                    if (dac_out !== mon_e.val || cyc != mon_e.cyc) begin
                        n_fail++;
                        $display("FAIL %s: actual %h at cycle %0d expected %h at cycle %0d",
                                 mon_e.req, dac_out, cyc, mon_e.val, mon_e.cyc);
                    end
                end
            end
            prev_dac = dac_out;
        end
    end

    task automatic wr_ctrl(input logic [7:0] v, output int p);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        p = cyc + 1;
        @(posedge clk);
        #1 ctrl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [DW-1:0] v, output int p);
        @(negedge clk);
        dat_we = 1'b1;
        dat_wdata = v;
        p = cyc + 1;
        @(posedge clk);
        #1 dat_we = 1'b0;
    endtask

    task automatic wr_mem(input int a, input logic [DW-1:0] v, output int p);
        @(negedge clk);
        mem_we = 1'b1;
        mem_waddr = AW'(a);
        mem_wdata = v;
        p = cyc + 1;
        @(posedge clk);
        #1 mem_we = 1'b0;
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    initial begin
        int p;
        int q;
        int r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 ctrl readback", int'(ctrl_rdata), 0);
        check_eq("R1 dac_out", int'(dac_out), 0);
        prev_dac = dac_out;
        mon_on = 1'b1;

        // R2: reserved bits read as zero
        phase = "R2";
        wr_ctrl(8'hC0, p);
        idle(1);
        check_eq("R2 reserved", int'(ctrl_rdata), 8'h00);
        wr_ctrl(8'hF8, p);
        idle(1);
        check_eq("R2 fields", int'(ctrl_rdata), 8'h38);

        // R3: static source
        phase = "R3";
        wr_dat(10'h2A5, p);
        push(p, 10'h2A5, "R3");
        for (int a = 0; a < 64; a++) wr_mem(a, mv(a), p);
        drain();
        idle(4);

        // R4 / R6 / R5: rising sweep at rate 7 (4 clocks)
        phase = "R6";
        wr_ctrl(8'h3D, p);
        push(p, mv(0), "R4");
        for (int k = 1; k <= 63; k++) push(p + 4 * k + 1, mv(k), "R6");
        drain();
        idle(40);
        check_eq("R6 hold top", int'(dac_out), int'(mv(63)));

        // R3: static write ignored while memory selected
        phase = "R3";
        wr_dat(10'h155, p);
        idle(10);
        check_eq("R3 static ignored", int'(dac_out), int'(mv(63)));

        // R12: read-first host write at the pointer location
        phase = "R12";
        wr_mem(63, 10'h201, p);
        push(p + 1, 10'h201, "R12");
        drain();
        wr_mem(63, mv(63), p);
        push(p + 1, mv(63), "R12");
        drain();
        idle(4);

        // R8: direction flipped on the edge of a due step
        phase = "R8";
        wr_ctrl(8'h39, p);
        for (int k = 1; k <= 10; k++) push(p + 4 * k + 1, mv(63 - k), "R8");
        wait_cyc(p + 42);
        wr_ctrl(8'h3D, q);
        check_eq("R5 collision edge", q, p + 44);
        for (int j = 1; j <= 53; j++) push(q + 4 * j + 1, mv(53 - j), "R8");
        for (int j = 54; j <= 116; j++) push(q + 4 * j + 1, mv(j - 53), "R8");
        drain();
        idle(20);

        // R11 / R7: freeze mid-sweep, resume, fall to bottom and hold
        phase = "R11";
        wr_ctrl(8'h39, p);
        for (int k = 1; k <= 5; k++) push(p + 4 * k + 1, mv(63 - k), "R11");
        wait_cyc(p + 22);
        wr_ctrl(8'h38, q);
        push(q, 10'h155, "R11");
        idle(60);
        wr_ctrl(8'h39, r);
        push(r, mv(58), "R11");
        for (int j = 1; j <= 58; j++) push(r + 4 * j + 1, mv(58 - j), "R7");
        phase = "R7";
        drain();
        idle(40);
        check_eq("R7 hold bottom", int'(dac_out), int'(mv(0)));

        // R9: triangle scan
        phase = "R9";
        wr_ctrl(8'h3F, p);
        for (int j = 1; j <= 130; j++) begin
            if (j <= 63)       push(p + 4 * j + 1, mv(j), "R9");
            else if (j <= 126) push(p + 4 * j + 1, mv(126 - j), "R9");
            else               push(p + 4 * j + 1, mv(j - 126), "R9");
        end
        drain();

        // R10: auto-cycle without memory source
        phase = "R10";
        wr_ctrl(8'h3E, p);
        push(p, 10'h155, "R10");
        idle(80);
        check_eq("R10 static held", int'(dac_out), 10'h155);
        check_eq("R2 readback", int'(ctrl_rdata), 8'h3E);

        // R5: slower rates
        phase = "R5";
        wr_ctrl(8'h2D, p);
        push(p, mv(4), "R4");
        for (int j = 1; j <= 5; j++) push(p + 16 * j + 1, mv(4 + j), "R5");
        drain();
        wr_ctrl(8'h05, q);
        for (int j = 1; j <= 2; j++) push(q + 512 * j + 1, mv(9 + j), "R5");
        drain();
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: watchdog, actual run incomplete expected finish", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule